// File: doc/BRIEF.md
# Shadow Stack Pointer Unit

This unit carries out return-address protection operations against a private stack pointer register and a single synchronous memory port. A decoder upstream hands it an operation code, the operand values it needs, the data-width mode and a start strobe. The unit answers with a done strobe, an optional register writeback value and a fault flag. It keeps one operation in flight at a time. The stack grows toward lower addresses, and every stack access is as wide as the current mode.

Five operations are supported. Push places a link value on the stack. Pop takes the top entry back. Read-pointer returns the current pointer. Link-compare checks that the two link registers agree. Swap atomically exchanges a memory word at an address taken from a register. The memory side uses a valid/ready request channel and a valid-only response channel. Each request carries a write select, a swap select and a width select.

Top module: `shstk_unit`

## Requirements
- R1: After reset the pointer holds the RESET_PTR parameter value, and done_o, fault_o, wb_valid_o and mreq_valid_o are low.
- R2: Push (op 0) issues one write request with mreq_write_o=1 at address pointer-4 in 32-bit mode (wide_i=0) or pointer-8 in 64-bit mode (wide_i=1), with opa_i as data. After the response the pointer equals that address, done_o pulses and wb_valid_o stays low.
- R3: Pop (op 1) issues one read request at the current pointer. After the response the pointer advances by 4 or 8 and done_o pulses together with wb_valid_o. The writeback is the response data in 64-bit mode, or its low 32 bits zero-extended in 32-bit mode.
- R4: Read-pointer (op 2) raises done_o and wb_valid_o one cycle after start, with wb_data_o equal to the pointer.
- R5: Link-compare (op 3) raises done_o one cycle after start with no writeback. fault_o is high exactly when link_x1_i and link_x5_i differ, comparing all 64 bits in 64-bit mode and only bits 31:0 in 32-bit mode.
- R6: Swap (op 4) issues one request with mreq_swap_o=1, address opa_i and data opb_i. The old value is written back, sign-extended from bit 31 in 32-bit mode. The pointer is not changed.
- R7: A push, pop or swap whose access address is not a multiple of 4 (32-bit mode) or 8 (64-bit mode) sends no request. It raises done_o and fault_o one cycle after start and leaves the pointer unchanged.
- R8: A request holds mreq_valid_o and all of its fields steady until mreq_ready_i is seen. The pointer changes only on the response, not before.
- R9: A start strobe that arrives while an operation is still in flight is ignored. It produces no done_o and no change to the result of the running operation.
- R10: The op codes 5, 6 and 7 raise done_o and fault_o one cycle after start, with no request and no writeback.
- R11: fault_o and wb_valid_o are high only together with done_o, and mreq_wide_o equals the mode that was latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the operation on op_i |
| op_i | input | 3 | Operation code (0 push, 1 pop, 2 read-pointer, 3 link-compare, 4 swap) |
| wide_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| opa_i | input | 64 | Push data, or swap address |
| opb_i | input | 64 | Swap data |
| link_x1_i | input | 64 | First link register value |
| link_x5_i | input | 64 | Alternate link register value |
| wb_valid_o | output | 1 | Writeback value is valid |
| wb_data_o | output | 64 | Writeback value |
| done_o | output | 1 | Operation finished this cycle |
| fault_o | output | 1 | Operation raised an illegal-instruction fault |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory accepts request |
| mreq_write_o | output | 1 | Request is a store |
| mreq_swap_o | output | 1 | Request is an atomic exchange |
| mreq_wide_o | output | 1 | Access is 8 bytes (else 4) |
| mreq_addr_o | output | 64 | Request address |
| mreq_wdata_o | output | 64 | Store or exchange data |
| mrsp_valid_i | input | 1 | Response valid |
| mrsp_data_i | input | 64 | Response data |

## Verification
The stack is exercised with nested pushes and pops in both modes. This separates the decrement-before-store order from the load-before-increment order, because each popped value must come back in reverse order from the address it was written to. A 32-bit push followed by 64-bit accesses drives the pointer onto a 4-byte boundary, which exposes the misalignment fault and shows whether the pointer stays put. The link-compare cases use operands that differ only in the upper half and operands that differ in the lower half, so the bench can tell a mode-aware compare from a full-width one. Repeated swaps on one address, with bit 31 set, tell sign extension apart from zero extension. The request-ready stall and response latency are varied, and one stall carries a stray start strobe.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

  parameter int unsigned SS_XLEN = 64;

  typedef enum logic [2:0] {
    SS_PUSH    = 3'd0,
    SS_POP     = 3'd1,
    SS_RDPTR   = 3'd2,
    SS_CHKLINK = 3'd3,
    SS_SWAP    = 3'd4
  } ss_op_e;

  // Bytes moved per stack entry in the selected mode.
  function automatic logic [SS_XLEN-1:0] ss_step(input logic wide);
    return wide ? SS_XLEN'(8) : SS_XLEN'(4);
  endfunction

  // Natural alignment for an access of the mode's width.
  function automatic logic ss_aligned(input logic [SS_XLEN-1:0] a, input logic wide);
    return wide ? (a[2:0] == 3'b000) : (a[1:0] == 2'b00);
  endfunction

  function automatic logic [SS_XLEN-1:0] ss_sext32(input logic [SS_XLEN-1:0] v);
    return {{(SS_XLEN-32){v[31]}}, v[31:0]};
  endfunction

  function automatic logic [SS_XLEN-1:0] ss_zext32(input logic [SS_XLEN-1:0] v);
    return {{(SS_XLEN-32){1'b0}}, v[31:0]};
  endfunction

  function automatic logic ss_links_differ(input logic [SS_XLEN-1:0] a,
                                           input logic [SS_XLEN-1:0] b,
                                           input logic wide);
    return wide ? (a != b) : (a[31:0] != b[31:0]);
  endfunction

endpackage

// File: rtl/shstk_addr_gen.sv
module shstk_addr_gen
  import shstk_pkg::*;
(
  input  logic [2:0]         op_i,
  input  logic               wide_i,
  input  logic [SS_XLEN-1:0] ptr_i,
  input  logic [SS_XLEN-1:0] opa_i,
  output logic [SS_XLEN-1:0] acc_addr_o,
  output logic [SS_XLEN-1:0] next_ptr_o,
  output logic               is_mem_o,
  output logic               misaligned_o
);

  logic [SS_XLEN-1:0] step;

  always_comb begin
    step       = ss_step(wide_i);
    acc_addr_o = ptr_i;
    next_ptr_o = ptr_i;
    is_mem_o   = 1'b0;
    case (op_i)
      SS_PUSH: begin
        acc_addr_o = ptr_i - step;
        next_ptr_o = ptr_i - step;
        is_mem_o   = 1'b1;
      end
      SS_POP: begin
        acc_addr_o = ptr_i;
        next_ptr_o = ptr_i + step;
        is_mem_o   = 1'b1;
      end
      SS_SWAP: begin
        acc_addr_o = opa_i;
        is_mem_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign misaligned_o = is_mem_o && !ss_aligned(acc_addr_o, wide_i);

endmodule

// File: rtl/shstk_ptr_reg.sv
module shstk_ptr_reg
  import shstk_pkg::*;
#(
  parameter logic [SS_XLEN-1:0] RESET_PTR = SS_XLEN'(64'h0001_0000)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_en_i,
  input  logic [SS_XLEN-1:0] upd_val_i,
  output logic [SS_XLEN-1:0] ptr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= RESET_PTR;
    else if (upd_en_i) ptr_o <= upd_val_i;
  end

endmodule

// File: rtl/shstk_mem_seq.sv
module shstk_mem_seq
  import shstk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               l_write_i,
  input  logic               l_swap_i,
  input  logic               l_wide_i,
  input  logic [SS_XLEN-1:0] l_addr_i,
  input  logic [SS_XLEN-1:0] l_wdata_i,
  output logic               busy_o,
  output logic               rsp_fire_o,
  output logic               mreq_valid_o,
  input  logic               mreq_ready_i,
  output logic               mreq_write_o,
  output logic               mreq_swap_o,
  output logic               mreq_wide_o,
  output logic [SS_XLEN-1:0] mreq_addr_o,
  output logic [SS_XLEN-1:0] mreq_wdata_o,
  input  logic               mrsp_valid_i
);

  typedef enum logic [1:0] {MS_IDLE, MS_REQ, MS_WAIT} ms_state_e;
  ms_state_e st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st           <= MS_IDLE;
      mreq_write_o <= 1'b0;
      mreq_swap_o  <= 1'b0;
      mreq_wide_o  <= 1'b0;
      mreq_addr_o  <= '0;
      mreq_wdata_o <= '0;
    end else begin
      case (st)
        MS_IDLE: if (launch_i) begin
          st           <= MS_REQ;
          mreq_write_o <= l_write_i;
          mreq_swap_o  <= l_swap_i;
          mreq_wide_o  <= l_wide_i;
          mreq_addr_o  <= l_addr_i;
          mreq_wdata_o <= l_wdata_i;
        end
        MS_REQ:  if (mreq_ready_i) st <= MS_WAIT;
        MS_WAIT: if (mrsp_valid_i) st <= MS_IDLE;
        default: st <= MS_IDLE;
      endcase
    end
  end

  assign mreq_valid_o = (st == MS_REQ);
  assign busy_o       = (st != MS_IDLE);
  assign rsp_fire_o   = (st == MS_WAIT) && mrsp_valid_i;

  // R8: an unaccepted request keeps every field
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o) &&
      $stable(mreq_wdata_o) && $stable(mreq_write_o) && $stable(mreq_swap_o)));

  // R9: no new launch while a request is outstanding
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !launch_i);

endmodule

// File: rtl/shstk_unit.sv
module shstk_unit
  import shstk_pkg::*;
#(
  parameter logic [SS_XLEN-1:0] RESET_PTR = SS_XLEN'(64'h0001_0000)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         op_i,
  input  logic               wide_i,
  input  logic [SS_XLEN-1:0] opa_i,
  input  logic [SS_XLEN-1:0] opb_i,
  input  logic [SS_XLEN-1:0] link_x1_i,
  input  logic [SS_XLEN-1:0] link_x5_i,
  output logic               wb_valid_o,
  output logic [SS_XLEN-1:0] wb_data_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               mreq_valid_o,
  input  logic               mreq_ready_i,
  output logic               mreq_write_o,
  output logic               mreq_swap_o,
  output logic               mreq_wide_o,
  output logic [SS_XLEN-1:0] mreq_addr_o,
  output logic [SS_XLEN-1:0] mreq_wdata_o,
  input  logic               mrsp_valid_i,
  input  logic [SS_XLEN-1:0] mrsp_data_i
);

  logic [SS_XLEN-1:0] ptr_q, acc_addr, next_ptr, cur_next;
  logic               is_mem, misaligned, seq_busy, rsp_fire;
  logic               accept_start, launch, ptr_upd;
  logic [2:0]         cur_op;
  logic               cur_wide;

  shstk_addr_gen u_addr (
    .op_i         (op_i),
    .wide_i       (wide_i),
    .ptr_i        (ptr_q),
    .opa_i        (opa_i),
    .acc_addr_o   (acc_addr),
    .next_ptr_o   (next_ptr),
    .is_mem_o     (is_mem),
    .misaligned_o (misaligned)
  );

  assign accept_start = start_i && !seq_busy;
  assign launch       = accept_start && is_mem && !misaligned;
  assign ptr_upd      = rsp_fire && ((cur_op == SS_PUSH) || (cur_op == SS_POP));

  shstk_ptr_reg #(.RESET_PTR(RESET_PTR)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (ptr_upd),
    .upd_val_i (cur_next),
    .ptr_o     (ptr_q)
  );

  shstk_mem_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .l_write_i    (op_i == SS_PUSH),
    .l_swap_i     (op_i == SS_SWAP),
    .l_wide_i     (wide_i),
    .l_addr_i     (acc_addr),
    .l_wdata_i    ((op_i == SS_PUSH) ? opa_i : opb_i),
    .busy_o       (seq_busy),
    .rsp_fire_o   (rsp_fire),
    .mreq_valid_o (mreq_valid_o),
    .mreq_ready_i (mreq_ready_i),
    .mreq_write_o (mreq_write_o),
    .mreq_swap_o  (mreq_swap_o),
    .mreq_wide_o  (mreq_wide_o),
    .mreq_addr_o  (mreq_addr_o),
    .mreq_wdata_o (mreq_wdata_o),
    .mrsp_valid_i (mrsp_valid_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_op     <= '0;
      cur_wide   <= 1'b0;
      cur_next   <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      wb_valid_o <= 1'b0;
      if (accept_start) begin
        cur_op   <= op_i;
        cur_wide <= wide_i;
        cur_next <= next_ptr;
        case (op_i)
          SS_RDPTR: begin
            done_o     <= 1'b1;
            wb_valid_o <= 1'b1;
            wb_data_o  <= ptr_q;
          end
          SS_CHKLINK: begin
            done_o  <= 1'b1;
            fault_o <= ss_links_differ(link_x1_i, link_x5_i, wide_i);
          end
          SS_PUSH, SS_POP, SS_SWAP: begin
            if (misaligned) begin
              done_o  <= 1'b1;
              fault_o <= 1'b1;
            end
          end
          default: begin
            done_o  <= 1'b1;
            fault_o <= 1'b1;
          end
        endcase
      end else if (rsp_fire) begin
        done_o <= 1'b1;
        if (cur_op == SS_POP) begin
          wb_valid_o <= 1'b1;
          wb_data_o  <= cur_wide ? mrsp_data_i : ss_zext32(mrsp_data_i);
        end else if (cur_op == SS_SWAP) begin
          wb_valid_o <= 1'b1;
          wb_data_o  <= cur_wide ? mrsp_data_i : ss_sext32(mrsp_data_i);
        end
      end
    end
  end

  // R11: fault and writeback appear only with completion
  a_r11_fault_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  a_r11_wb_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);

  // R7: only aligned requests reach the memory port
  a_r7_req_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o |-> ss_aligned(mreq_addr_o, mreq_wide_o));

  // R7: a faulting operation leaves the pointer where it was
  a_r7_fault_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(ptr_q));

  // R2: after a push the pointer equals the address that was stored to
  a_r2_push_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fire && cur_op == SS_PUSH) |=> (ptr_q == $past(mreq_addr_o)));

  // R3: after a pop the pointer moves one entry above the loaded address
  a_r3_pop_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fire && cur_op == SS_POP) |=>
      (ptr_q == $past(mreq_addr_o) + ss_step($past(cur_wide))));

  // R6: swap never moves the pointer
  a_r6_swap_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fire && cur_op == SS_SWAP) |=> $stable(ptr_q));

  // R8: pointer is frozen while a request is in flight
  a_r8_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && !rsp_fire) |=> $stable(ptr_q));

endmodule

// File: tb/shstk_unit_bench.sv
module shstk_unit_bench;
  import shstk_pkg::*;

  localparam logic [63:0] RST_PTR = 64'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_s = 3'd0;
  logic        wide = 1'b0;
  logic [63:0] opa = '0, opb = '0, lx1 = '0, lx5 = '0;
  logic        wb_valid, done, fault;
  logic [63:0] wb_data;
  logic        mreq_valid, mreq_write, mreq_swap, mreq_wide;
  logic        mreq_ready = 1'b0;
  logic [63:0] mreq_addr, mreq_wdata;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  // 4 ns period
  always #2 clk = ~clk;

  shstk_unit #(.RESET_PTR(RST_PTR)) u_shstk_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op_s), .wide_i(wide),
    .opa_i(opa), .opb_i(opb), .link_x1_i(lx1), .link_x5_i(lx5),
    .wb_valid_o(wb_valid), .wb_data_o(wb_data), .done_o(done), .fault_o(fault),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready), .mreq_write_o(mreq_write),
    .mreq_swap_o(mreq_swap), .mreq_wide_o(mreq_wide), .mreq_addr_o(mreq_addr),
    .mreq_wdata_o(mreq_wdata), .mrsp_valid_i(mrsp_valid), .mrsp_data_i(mrsp_data)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] m_ptr;
  logic [63:0] mem_m [logic [63:0]];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R11: every clock, fault and writeback only alongside done
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 fault implies done", {63'd0, fault && !done}, 64'd0);
      chk("R11 wb implies done", {63'd0, wb_valid && !done}, 64'd0);
    end
  end

  task automatic issue(input logic [2:0] op, input logic w, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] l1, input logic [63:0] l5);
    @(negedge clk);
    start = 1'b1; op_s = op; wide = w; opa = a; opb = b; lx1 = l1; lx5 = l5;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_rdptr(input logic w, input string req);
    issue(SS_RDPTR, w, 64'd0, 64'd0, 64'd0, 64'd0);
    chk({req, " rdptr done"}, {63'd0, done}, 64'd1);
    chk({req, " rdptr wbv"}, {63'd0, wb_valid}, 64'd1);
    chk({req, " rdptr value"}, wb_data, m_ptr);
    chk({req, " rdptr fault"}, {63'd0, fault}, 64'd0);
  endtask

  task automatic run_chk(input logic w, input logic [63:0] l1, input logic [63:0] l5);
    logic exp_f;
    exp_f = w ? (l1 != l5) : (l1[31:0] != l5[31:0]);
    issue(SS_CHKLINK, w, 64'd0, 64'd0, l1, l5);
    chk("R5 done", {63'd0, done}, 64'd1);
    chk("R5 fault", {63'd0, fault}, {63'd0, exp_f});
    chk("R5 no wb", {63'd0, wb_valid}, 64'd0);
  endtask

  task automatic run_bad(input logic [2:0] op);
    issue(op, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    chk("R10 done", {63'd0, done}, 64'd1);
    chk("R10 fault", {63'd0, fault}, 64'd1);
    chk("R10 no req", {63'd0, mreq_valid}, 64'd0);
  endtask

  task automatic run_mem(input logic [2:0] op, input logic w, input logic [63:0] a,
                         input logic [63:0] b, input int stall, input int lat,
                         input logic poke, input string req);
    logic [63:0] step, eaddr, ewdata, old, ewb;
    logic        mis;
    step  = w ? 64'd8 : 64'd4;
    eaddr = (op == SS_PUSH) ? m_ptr - step : (op == SS_POP) ? m_ptr : a;
    mis   = w ? (eaddr[2:0] != 3'd0) : (eaddr[1:0] != 2'd0);
    ewdata = (op == SS_PUSH) ? a : b;
    issue(op, w, a, b, 64'd0, 64'd0);
    if (mis) begin
      chk({req, " R7 done"}, {63'd0, done}, 64'd1);
      chk({req, " R7 fault"}, {63'd0, fault}, 64'd1);
      chk({req, " R7 no req"}, {63'd0, mreq_valid}, 64'd0);
      return;
    end
    chk({req, " no early done"}, {63'd0, done}, 64'd0);
    chk({req, " req valid"}, {63'd0, mreq_valid}, 64'd1);
    chk({req, " req addr"}, mreq_addr, eaddr);
    chk({req, " req write"}, {63'd0, mreq_write}, {63'd0, op == SS_PUSH});
    chk({req, " req swap"}, {63'd0, mreq_swap}, {63'd0, op == SS_SWAP});
    chk({req, " R11 req wide"}, {63'd0, mreq_wide}, {63'd0, w});
    if (op != SS_POP) chk({req, " req wdata"}, mreq_wdata, ewdata);
    for (int i = 0; i < stall; i++) begin
      if (poke && i == 0) begin
        start = 1'b1; op_s = SS_RDPTR;
      end
      @(negedge clk);
      start = 1'b0;
      chk({req, " R8 req held"}, {63'd0, mreq_valid}, 64'd1);
      chk({req, " R8 addr held"}, mreq_addr, eaddr);
      chk({req, " R9 no done while busy"}, {63'd0, done}, 64'd0);
    end
    mreq_ready = 1'b1;
    @(negedge clk);
    mreq_ready = 1'b0;
    chk({req, " req dropped"}, {63'd0, mreq_valid}, 64'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk({req, " R8 wait"}, {63'd0, done}, 64'd0);
    end
    old = mem_m.exists(eaddr) ? mem_m[eaddr] : 64'd0;
    mrsp_valid = 1'b1;
    mrsp_data  = (op == SS_PUSH) ? 64'hA5A5_5A5A_0F0F_F0F0 : old;
    @(negedge clk);
    mrsp_valid = 1'b0;
    ewb = 64'd0;
    if (op == SS_PUSH) begin
      mem_m[eaddr] = w ? a : {32'd0, a[31:0]};
      m_ptr = eaddr;
    end else if (op == SS_POP) begin
      m_ptr = m_ptr + step;
      ewb = w ? old : {32'd0, old[31:0]};
    end else begin
      mem_m[eaddr] = w ? b : {32'd0, b[31:0]};
      ewb = w ? old : {{32{old[31]}}, old[31:0]};
    end
    chk({req, " done"}, {63'd0, done}, 64'd1);
    chk({req, " fault"}, {63'd0, fault}, 64'd0);
    chk({req, " wbv"}, {63'd0, wb_valid}, {63'd0, op != SS_PUSH});
    if (op != SS_PUSH) chk({req, " wb data"}, wb_data, ewb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_ptr = RST_PTR;
    repeat (3) @(negedge clk);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 fault", {63'd0, fault}, 64'd0);
    chk("R1 wbv", {63'd0, wb_valid}, 64'd0);
    chk("R1 req", {63'd0, mreq_valid}, 64'd0);
    rst_n = 1'b1;
    run_rdptr(1'b1, "R1 R4");

    // nested push/pop in 64-bit mode, varied stall and latency
    run_mem(SS_PUSH, 1'b1, 64'h1111_2222_3333_4444, 64'd0, 2, 1, 1'b0, "R2 push64 a");
    run_mem(SS_PUSH, 1'b1, 64'h9999_8888_7777_6666, 64'd0, 0, 0, 1'b0, "R2 push64 b");
    run_rdptr(1'b1, "R4 after pushes");
    run_mem(SS_POP, 1'b1, 64'd0, 64'd0, 1, 3, 1'b0, "R3 pop64 b");
    run_mem(SS_POP, 1'b1, 64'd0, 64'd0, 0, 0, 1'b0, "R3 pop64 a");
    run_rdptr(1'b1, "R4 back to reset");

    // 32-bit mode, pop zero-extends
    run_mem(SS_PUSH, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'd0, 1, 1, 1'b0, "R2 push32");
    run_rdptr(1'b0, "R4 after push32");
    // pointer now on a 4-byte boundary: 64-bit accesses misaligned
    run_mem(SS_PUSH, 1'b1, 64'h1234, 64'd0, 0, 0, 1'b0, "R7 push64 mis");
    run_mem(SS_POP, 1'b1, 64'd0, 64'd0, 0, 0, 1'b0, "R7 pop64 mis");
    run_rdptr(1'b1, "R7 ptr unchanged");
    run_mem(SS_POP, 1'b0, 64'd0, 64'd0, 2, 2, 1'b0, "R3 pop32");

    // link compare
    run_chk(1'b1, 64'h0000_0001_0000_1000, 64'h0000_0001_0000_1000);
    run_chk(1'b1, 64'h0000_0001_0000_1000, 64'h0000_0002_0000_1000);
    run_chk(1'b0, 64'h0000_0001_0000_1000, 64'h0000_0002_0000_1000);
    run_chk(1'b0, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_1004);

    // swap
    run_mem(SS_SWAP, 1'b1, 64'h200, 64'h0123_4567_89AB_CDEF, 1, 0, 1'b0, "R6 swap64 first");
    run_mem(SS_SWAP, 1'b1, 64'h200, 64'h55, 0, 1, 1'b0, "R6 swap64 second");
    run_mem(SS_SWAP, 1'b0, 64'h300, 64'h0000_0000_8000_0001, 0, 0, 1'b0, "R6 swap32 first");
    run_mem(SS_SWAP, 1'b0, 64'h300, 64'h5, 1, 1, 1'b0, "R6 swap32 sext");
    run_mem(SS_SWAP, 1'b1, 64'h204, 64'h7, 0, 0, 1'b0, "R7 swap64 mis");
    run_mem(SS_SWAP, 1'b0, 64'h302, 64'h7, 0, 0, 1'b0, "R7 swap32 mis");
    run_rdptr(1'b1, "R6 ptr after swaps");

    // stray start while busy
    run_mem(SS_PUSH, 1'b1, 64'h4242_4242_4242_4242, 64'd0, 3, 1, 1'b1, "R9 push busy");
    run_mem(SS_POP, 1'b1, 64'd0, 64'd0, 2, 0, 1'b1, "R9 pop busy");
    run_rdptr(1'b1, "R9 ptr");

    run_bad(3'd5);
    run_bad(3'd7);
    run_rdptr(1'b1, "R10 ptr kept");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule